// File: doc/BRIEF.md
# I/O-Port Page Mapper for a 16-bit CPU Address Space

This block sits on a memory expansion card of an 8-bit processor whose address bus is 16 bits wide. It watches I/O write cycles. When the processor writes to one fixed I/O port, the block keeps the low four data bits as its current page number. Several cards can watch the same port, and each one keeps its own copy of the number. No card drives the port back, so software cannot read it.

Every memory access is turned into a 19-bit physical address. The bottom half of CPU space (0x0000–0x7FFF) is always page 0. The top half (0x8000–0xFFFF) is a 32K window that shows whichever of the 16 pages was last selected. The physical address is {page, cpu_addr[14:0]}. A card-select output is raised for memory requests that land on a page inside the range this card is built to hold.

Both outputs are registered. Each shows the inputs of the previous clock edge. A port write and a memory access in the same cycle are mapped with the page that was held before that write.

Top module: `iobank_mapper`

## Requirements
- R1: While reset is high and on the first edge after it, the page register is 0, phys_addr is 0 and card_sel is 0.
- R2: A cycle with io_wr high and cpu_addr[7:0] equal to PORT_ADDR (default 0xFF) loads cpu_data[3:0] into the page register. cpu_data[7:4] has no effect on the page.
- R3: Only cpu_addr[7:0] is decoded for the port. cpu_addr[15:8] does not matter, and a write whose low address byte is not PORT_ADDR leaves the page unchanged.
- R4: When io_wr is low, the page does not change, whatever the address and data.
- R5: When cpu_addr[15] is 0, phys_addr[18:15] is 0 whatever the page register holds.
- R6: When cpu_addr[15] is 1, phys_addr[18:15] is the page register and phys_addr[14:0] is cpu_addr[14:0].
- R7: phys_addr and card_sel change one clock edge after the inputs that set them. An access in the same cycle as a port write uses the page held before that write.
- R8: card_sel is 1 only when mem_req was high and the resulting page lies in PAGE_LO..PAGE_HI, both ends included.
- R9: A page value of 0 selected for the top window maps the top half onto the same physical page as the bottom half. This is not treated as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| io_wr | input | 1 | I/O write strobe, active high |
| mem_req | input | 1 | Memory request strobe, active high |
| phys_addr | output | 19 | Registered physical address |
| card_sel | output | 1 | Registered chip enable for the card RAM |

## Verification
The bench builds the block with PAGE_LO=2 and PAGE_HI=9. With that range, page 0 (the whole bottom half) lies outside the card, and so do pages 1 and 10–15. Pages 2 and 9 sit on the range edges, so the window compare is tested on both sides of each bound. The default port address 0xFF is kept. Stimulus varies the high address byte and the high data nibble, so that decode and data bits the design must ignore are shown to have no effect.

// File: rtl/iobank_pkg.sv
package iobank_pkg;
  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_e;

  function automatic half_e half_of(input logic top_bit);
    return top_bit ? HALF_HIGH : HALF_LOW;
  endfunction
endpackage

// File: rtl/iobank_port_decode.sv
module iobank_port_decode #(
  parameter int unsigned DEC_W = 8,
  parameter logic [DEC_W-1:0] PORT_ADDR = '1
) (
  input  logic [DEC_W-1:0] addr_lo,
  input  logic             io_wr,
  output logic             hit
);
  assign hit = io_wr && (addr_lo == PORT_ADDR);
endmodule

// File: rtl/iobank_page_latch.sv
module iobank_page_latch #(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst)       page <= '0;
    else if (load) page <= din;
  end
endmodule

// File: rtl/iobank_addr_map.sv
module iobank_addr_map
  import iobank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned PAGE_LO = 0,
  parameter int unsigned PAGE_HI = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     mem_req,
  input  logic [PAGE_W-1:0]        page,
  output logic [PAGE_W+ADDR_W-2:0] phys_addr,
  output logic                     card_sel
);
  localparam int unsigned OFF_W    = ADDR_W - 1;
  localparam int unsigned PAGE_MAX = (1 << PAGE_W) - 1;
  localparam logic [PAGE_W-1:0] LO_P = PAGE_LO[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] HI_P = PAGE_HI[PAGE_W-1:0];

  half_e             half;
  logic [PAGE_W-1:0] eff_page;
  logic              in_rng;

  always_comb begin
    half     = half_of(cpu_addr[ADDR_W-1]);
    eff_page = (half == HALF_HIGH) ? page : '0;
  end

  generate
    if (PAGE_LO == 0 && PAGE_HI >= PAGE_MAX) begin : g_full
      assign in_rng = 1'b1;
    end else if (PAGE_LO == 0) begin : g_top_only
      assign in_rng = (eff_page <= HI_P);
    end else if (PAGE_HI >= PAGE_MAX) begin : g_bot_only
      assign in_rng = (eff_page >= LO_P);
    end else begin : g_both
      assign in_rng = (eff_page >= LO_P) && (eff_page <= HI_P);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      card_sel  <= 1'b0;
    end else begin
      phys_addr <= {eff_page, cpu_addr[OFF_W-1:0]};
      card_sel  <= mem_req && in_rng;
    end
  end
endmodule

// File: rtl/iobank_mapper.sv
module iobank_mapper #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned DEC_W     = 8,
  parameter int unsigned PORT_ADDR = 255,
  parameter int unsigned PAGE_LO   = 0,
  parameter int unsigned PAGE_HI   = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_data,
  input  logic                     io_wr,
  input  logic                     mem_req,
  output logic [PAGE_W+ADDR_W-2:0] phys_addr,
  output logic                     card_sel
);
  logic              port_hit;
  logic [PAGE_W-1:0] page_q;
  logic              unused_hi_data;

  assign unused_hi_data = ^cpu_data[DATA_W-1:PAGE_W];

  iobank_port_decode #(
    .DEC_W(DEC_W), .PORT_ADDR(PORT_ADDR[DEC_W-1:0])
  ) u_dec (
    .addr_lo(cpu_addr[DEC_W-1:0]), .io_wr(io_wr), .hit(port_hit)
  );

  iobank_page_latch #(.PAGE_W(PAGE_W)) u_latch (
    .clk(clk), .rst(rst), .load(port_hit),
    .din(cpu_data[PAGE_W-1:0]), .page(page_q)
  );

  iobank_addr_map #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI)
  ) u_map (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .page(page_q), .phys_addr(phys_addr), .card_sel(card_sel)
  );
endmodule

// File: rtl/iobank_mapper_chk.sv
module iobank_mapper_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned DEC_W     = 8,
  parameter int unsigned PORT_ADDR = 255
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        cpu_addr,
  input logic [DATA_W-1:0]        cpu_data,
  input logic                     io_wr,
  input logic                     mem_req,
  input logic [PAGE_W-1:0]        page_q,
  input logic [PAGE_W+ADDR_W-2:0] phys_addr,
  input logic                     card_sel
);
  localparam int unsigned PW = PAGE_W + ADDR_W - 1;
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      reset_state_chk: assert (page_q == '0 && card_sel == 1'b0 && phys_addr == '0);
    end
  end

  // R2
  port_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && cpu_addr[DEC_W-1:0] == PORT_ADDR[DEC_W-1:0])
      |=> page_q == $past(cpu_data[PAGE_W-1:0]));

  // R4
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> $stable(page_q));

  // R5
  low_half_page0_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_addr[ADDR_W-1] |=> phys_addr[PW-1:ADDR_W-1] == '0);

  // R6
  high_half_page_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[ADDR_W-1] |=> phys_addr[PW-1:ADDR_W-1] == $past(page_q));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phys_addr[ADDR_W-2:0] == $past(cpu_addr[ADDR_W-2:0]));

  // R8
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> !card_sel);
endmodule

bind iobank_mapper iobank_mapper_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
  .DEC_W(DEC_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .io_wr(io_wr), .mem_req(mem_req), .page_q(page_q),
  .phys_addr(phys_addr), .card_sel(card_sel)
);

// File: tb/iobank_mapper_bench.sv
`timescale 1ns/1ps
module iobank_mapper_bench;
  localparam int LO = 2;
  localparam int HI = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        io_wr = 1'b0;
  logic        mem_req = 1'b0;
  logic [18:0] phys_addr;
  logic        card_sel;

  int checks = 0;
  int errors = 0;
  int model_page = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iobank_mapper #(.PAGE_LO(LO), .PAGE_HI(HI)) u_iobank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .io_wr(io_wr), .mem_req(mem_req), .phys_addr(phys_addr), .card_sel(card_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive, model the edge, compare at the following negedge.
  task automatic step(input string tag, input int a, input int d,
                      input bit iow, input bit mreq);
    int pg, exp_a;
    bit exp_s;
    cpu_addr = a[15:0]; cpu_data = d[7:0]; io_wr = iow; mem_req = mreq;
    @(posedge clk);
    pg    = (a >= 32768) ? model_page : 0;
    exp_a = pg * 32768 + (a % 32768);
    exp_s = mreq && pg >= LO && pg <= HI;
    if (iow && (a % 256) == 255) model_page = d % 16;
    @(negedge clk);
    check({tag, " addr"}, int'(phys_addr), exp_a);
    check({tag, " sel"}, int'(card_sel), int'(exp_s));
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state, even with live inputs
    cpu_addr = 16'hFFFF; cpu_data = 8'h07; io_wr = 1'b1; mem_req = 1'b1;
    @(negedge clk);
    check("R1 reset addr", int'(phys_addr), 0);
    check("R1 reset sel", int'(card_sel), 0);
    rst = 1'b0;
    step("R1 after reset upper window", 'h8123, 0, 0, 1);
    // R2: port write, upper nibble ignored
    step("R2 write 0xA5", 'h00FF, 'hA5, 1, 0);
    step("R2 read page5", 'hC001, 0, 0, 1);
    // R3: high address byte ignored in decode
    step("R3 write via 0x12FF", 'h12FF, 'h03, 1, 0);
    step("R3 read page3", 'hFFFF, 0, 0, 1);
    // R3: other port does not load
    step("R3 write 0x41", 'h0041, 'h07, 1, 0);
    step("R3 write 0xFE", 'h00FE, 'h07, 1, 0);
    step("R3 page still 3", 'h8000, 0, 0, 1);
    // R4: io_wr low with port address
    step("R4 no strobe", 'h00FF, 'h0C, 0, 1);
    step("R4 page still 3", 'hA5A5, 0, 0, 1);
    // R5: lower half pinned to page 0 under various pages
    step("R5 low max", 'h7FFF, 0, 0, 1);
    step("R2 write 0x9", 'hFFFF, 'hF9, 1, 0);
    step("R5 low again", 'h1234, 0, 0, 1);
    // R6/R8: range edges
    step("R8 page9 edge", 'h8000, 0, 0, 1);
    step("R2 write 10", 'hABFF, 'h0A, 1, 0);
    step("R8 page10 out", 'h9000, 0, 0, 1);
    step("R2 write 2", 'h00FF, 'h32, 1, 0);
    step("R8 page2 edge", 'hBEEF, 0, 0, 1);
    step("R2 write 1", 'h00FF, 'h01, 1, 0);
    step("R8 page1 out", 'hF00F, 0, 0, 1);
    step("R8 no req", 'hF00F, 0, 0, 0);
    step("R2 write 15", 'h00FF, 'h0F, 1, 0);
    step("R6 page15", 'hFFFF, 0, 0, 1);
    // R7: write and access in same cycle uses old page
    step("R7 same cycle", 'h80FF, 'h04, 1, 1);
    step("R7 next uses new", 'h80FF, 0, 0, 1);
    // R9: page 0 in upper window mirrors lower
    step("R9 write 0", 'h00FF, 'hF0, 1, 0);
    step("R9 upper mirror", 'hC321, 0, 0, 1);
    step("R9 lower same", 'h4321, 0, 0, 1);
    // sweep of all pages
    for (int p = 0; p < 16; p++) begin
      step("R2 sweep write", 'h00FF, p + 16 * (15 - p), 1, 0);
      step("R6 sweep read", 'h8000 + p * 1021, 0, 0, 1);
    end
    // R1: reset mid-run clears page
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 mid reset addr", int'(phys_addr), 0);
    check("R1 mid reset sel", int'(card_sel), 0);
    rst = 1'b0;
    model_page = 0;
    step("R1 page cleared", 'hFFFF, 0, 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule